// File: doc/BRIEF.md
# Dual-Rail Stage Completion and Sleep Generator

This block closes the handshake loop of one stage in a sleep-gated dual-rail pipeline. A bus of WIDTH bits arrives as two rails per bit. Each bit counts as holding DATA when either of its rails is high, and NULL when both rails are low. A tree of narrow AND nodes combines the per-bit results into one stage-complete flag. Every node in the tree is forced low by the stage's incoming sleep signal, so the tree clears at once when the stage sleeps. It does not wait for a NULL wavefront to ripple through.

The complete flag and a ready indication from the following stage feed a hysteresis element. This element moves high only when both inputs are high and moves low only when both are low. In every other case it keeps its value. Its inverted output is the sleep signal that this stage hands on. After reset that sleep signal is asserted. The hysteresis element takes no sleep input, so it is always active. It is modelled as a clocked state bit with a clock enable that is active only while its inputs agree.

Top module: `cdet_stage`

## Requirements
- R1: `complete_o` is high exactly when `stage_sleep_i` is low and, for every bit i, `rail0_i[i]` or `rail1_i[i]` is high. The output is combinational, in the same cycle as its inputs.
- R2: If any single bit has both rails low, `complete_o` stays low, even when every other bit carries DATA.
- R3: While `stage_sleep_i` is high, `complete_o` is low whatever the rails carry.
- R4: If `complete_o` and `downstream_i` are both high before a rising clock edge, `sleep_o` is low after that edge.
- R5: If `complete_o` and `downstream_i` are both low before a rising clock edge, `sleep_o` is high after that edge.
- R6: If `complete_o` and `downstream_i` differ before a rising clock edge, `sleep_o` keeps its value across that edge.
- R7: While `rst_n` is low, and for the first two rising edges after it rises, `sleep_o` is high.
- R8: The detector is built for any WIDTH of 1 or more. Each node has at most GROUP inputs (2 to 4), and the tree has as many levels as that grouping needs.
- R9: A single DATA set followed by a NULL set drives `complete_o` high then low, and `sleep_o` low then high, in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the hysteresis state |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rail0_i | input | WIDTH | Zero rail of each dual-rail bit |
| rail1_i | input | WIDTH | One rail of each dual-rail bit |
| stage_sleep_i | input | 1 | Sleep for this stage; clears the whole detector |
| downstream_i | input | 1 | Ready/completion indication from the following stage |
| complete_o | output | 1 | Every bit holds DATA and the stage is awake |
| sleep_o | output | 1 | Inverted hysteresis output, used as the sleep signal passed on |

## Verification
The bench builds the block with WIDTH = 13 and GROUP = 4. With these values the first AND level has three full nodes and one single-input node, and a second level follows. A clipped group at the edge of the bus is therefore exercised, and so is a tree deeper than one level. Nulling each of the 13 bits in turn reaches every leaf of that irregular tree. Random rails, random stage sleep and random downstream readiness drive the hysteresis element through agreeing and disagreeing input pairs in many orders.

// File: rtl/cdet_pkg.sv
package cdet_pkg;

  typedef enum logic {
    HYS_LOW  = 1'b0,
    HYS_HIGH = 1'b1
  } hys_state_e;

  // width of tree level k when n leaves are grouped g at a time
  function automatic int level_width(int n, int k, int g);
    int w;
    w = n;
    for (int i = 0; i < k; i++) w = (w + g - 1) / g;
    return w;
  endfunction

  // number of reduction levels needed to reach a single node
  function automatic int tree_levels(int n, int g);
    int w;
    int l;
    w = n;
    l = 0;
    while (w > 1) begin
      w = (w + g - 1) / g;
      l++;
    end
    return l;
  endfunction

  // first flat index of level k
  function automatic int level_offset(int n, int k, int g);
    int s;
    s = 0;
    for (int i = 0; i < k; i++) s += level_width(n, i, g);
    return s;
  endfunction

endpackage

// File: rtl/cdet_rst_sync.sv
module cdet_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/cdet_bit_or.sv
module cdet_bit_or #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] rail0_i,
  input  logic [WIDTH-1:0] rail1_i,
  input  logic             sleep_i,
  output logic [WIDTH-1:0] hit_o
);

  // one two-input OR per bit, held low while asleep
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign hit_o[b] = (rail0_i[b] | rail1_i[b]) & ~sleep_i;
  end

endmodule

// File: rtl/cdet_and_tree.sv
module cdet_and_tree
  import cdet_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] leaf_i,
  input  logic             sleep_i,
  output logic             done_o
);

  localparam int LEVELS = tree_levels(WIDTH, GROUP);
  localparam int TOTAL  = level_offset(WIDTH, LEVELS + 1, GROUP);

  logic [TOTAL-1:0] node;

  assign node[WIDTH-1:0] = leaf_i;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    localparam int WI    = level_width(WIDTH, k, GROUP);
    localparam int WO    = level_width(WIDTH, k + 1, GROUP);
    localparam int OFF_I = level_offset(WIDTH, k, GROUP);
    localparam int OFF_O = level_offset(WIDTH, k + 1, GROUP);
    for (genvar j = 0; j < WO; j++) begin : g_node
      localparam int LO = j * GROUP;
      localparam int HI = (LO + GROUP - 1 < WI - 1) ? LO + GROUP - 1 : WI - 1;
      assign node[OFF_O+j] = (&node[OFF_I+HI:OFF_I+LO]) & ~sleep_i;
    end
  end

  assign done_o = node[TOTAL-1];

endmodule

// File: rtl/cdet_hys.sv
module cdet_hys
  import cdet_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_i,
  input  logic b_i,
  output logic q_n_o
);

  hys_state_e state_q;
  hys_state_e state_d;
  logic       agree_en;

  assign agree_en = (a_i == b_i);

  always_comb begin
    state_d = state_q;
    if (a_i && b_i)        state_d = HYS_HIGH;
    else if (!a_i && !b_i) state_d = HYS_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= HYS_LOW;
    else if (agree_en) state_q <= state_d;
  end

  assign q_n_o = (state_q == HYS_LOW);

endmodule

// File: rtl/cdet_stage.sv
module cdet_stage #(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rail0_i,
  input  logic [WIDTH-1:0] rail1_i,
  input  logic             stage_sleep_i,
  input  logic             downstream_i,
  output logic             complete_o,
  output logic             sleep_o
);

  logic             rst_sync_n;
  logic [WIDTH-1:0] bit_hit;
  logic             tree_done;

  cdet_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cdet_bit_or #(.WIDTH(WIDTH)) u_or (
    .rail0_i (rail0_i),
    .rail1_i (rail1_i),
    .sleep_i (stage_sleep_i),
    .hit_o   (bit_hit)
  );

  cdet_and_tree #(.WIDTH(WIDTH), .GROUP(GROUP)) u_tree (
    .leaf_i  (bit_hit),
    .sleep_i (stage_sleep_i),
    .done_o  (tree_done)
  );

  assign complete_o = tree_done;

  cdet_hys u_hys (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .a_i   (tree_done),
    .b_i   (downstream_i),
    .q_n_o (sleep_o)
  );

endmodule

// File: rtl/cdet_stage_chk.sv
module cdet_stage_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] rail0_i,
  input logic [WIDTH-1:0] rail1_i,
  input logic             stage_sleep_i,
  input logic             downstream_i,
  input logic             complete_o,
  input logic             sleep_o
);

  // R1 / R2: completion only with DATA on every bit
  a_r2_no_partial_complete: assert property (@(posedge clk) disable iff (!rst_n)
    complete_o |-> (&(rail0_i | rail1_i)));

  // R3: sleep clears the detector
  a_r3_sleep_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stage_sleep_i |-> !complete_o);

  // R4
  a_r4_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (complete_o && downstream_i) |=> !sleep_o);

  // R5
  a_r5_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (!complete_o && !downstream_i) |=> sleep_o);

  // R6
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (complete_o != downstream_i) |=> $stable(sleep_o));

  // R7
  a_r7_reset_sleep: assert property (@(posedge clk)
    !rst_n |-> sleep_o);

endmodule

bind cdet_stage cdet_stage_chk #(.WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .rail0_i       (rail0_i),
  .rail1_i       (rail1_i),
  .stage_sleep_i (stage_sleep_i),
  .downstream_i  (downstream_i),
  .complete_o    (complete_o),
  .sleep_o       (sleep_o)
);

// File: tb/tb_cdet_stage.sv
module tb_cdet_stage;

  localparam int W      = 13;
  localparam int PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] rail0;
  logic [W-1:0] rail1;
  logic         stage_sleep;
  logic         downstream;
  logic         complete;
  logic         sleep;

  int checks;
  int errors;
  bit exp_c;

  cdet_stage #(.WIDTH(W), .GROUP(4)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .rail0_i       (rail0),
    .rail1_i       (rail1),
    .stage_sleep_i (stage_sleep),
    .downstream_i  (downstream),
    .complete_o    (complete),
    .sleep_o       (sleep)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  function automatic bit exp_complete(logic [W-1:0] r0, logic [W-1:0] r1, logic sl);
    return !sl && (&(r0 | r1));
  endfunction

  function automatic bit exp_next(bit c, bit a, bit b);
    if (a && b) return 1'b1;
    if (!a && !b) return 1'b0;
    return c;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a falling edge; drives, checks complete, then sleep after the edge
  task automatic step(logic [W-1:0] r0, logic [W-1:0] r1, logic sl, logic nx);
    bit    ec;
    string stag;
    rail0 = r0; rail1 = r1; stage_sleep = sl; downstream = nx;
    #1;
    ec = exp_complete(r0, r1, sl);
    check(complete == ec, sl ? "R3" : (ec ? "R1" : "R2"), complete, ec);
    if (ec && nx)        stag = "R4";
    else if (!ec && !nx) stag = "R5";
    else                 stag = "R6";
    exp_c = exp_next(exp_c, ec, nx);
    @(negedge clk);
    check(sleep == !exp_c, stag, sleep, !exp_c);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] ones;
    checks = 0; errors = 0; exp_c = 1'b0;
    ones = '1;
    void'($urandom(32'd7261));
    rst_n = 1'b0; rail0 = '0; rail1 = '0; stage_sleep = 1'b0; downstream = 1'b0;
    repeat (3) @(negedge clk);
    check(sleep == 1'b1, "R7 in reset", sleep, 1);
    rail1 = ones; downstream = 1'b1;
    @(negedge clk);
    check(sleep == 1'b1, "R7 held in reset", sleep, 1);
    rail1 = '0; downstream = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(sleep == 1'b1, "R7 after release 1", sleep, 1);
    @(negedge clk);
    check(sleep == 1'b1, "R7 after release 2", sleep, 1);

    // R9: one DATA/NULL pair
    v = 13'h0b5a;
    step(~v, v, 1'b0, 1'b1);
    check(sleep == 1'b0, "R9 data wakes", sleep, 0);
    step('0, '0, 1'b1, 1'b1);
    check(complete == 1'b0, "R9 null clears", complete, 0);
    step('0, '0, 1'b0, 1'b0);
    check(sleep == 1'b1, "R9 null sleeps", sleep, 1);

    // R2 / R8: each bit nulled in turn blocks completion
    for (int b = 0; b < W; b++) begin
      logic [W-1:0] r0;
      logic [W-1:0] r1;
      r1 = ones; r0 = '0;
      r1[b] = 1'b0;
      step(r0, r1, 1'b0, 1'b1);
      check(sleep == 1'b1, "R2 deadlock bit", sleep, 1);
    end

    // R3: full DATA while asleep
    step(ones, '0, 1'b1, 1'b1);
    // R1: all-zero data values still complete
    step(ones, '0, 1'b0, 1'b1);
    // R6: disagreeing inputs hold
    step('0, ones, 1'b0, 1'b0);
    step('0, '0, 1'b0, 1'b1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] r0;
      logic [W-1:0] r1;
      int idx;
      v = W'($urandom);
      r1 = v; r0 = ~v;
      if (($urandom % 4) == 0) begin
        idx = int'($urandom % W);
        r0[idx] = 1'b0; r1[idx] = 1'b0;
      end
      step(r0, r1, ($urandom % 5) == 0, $urandom % 2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule